// File: doc/BRIEF.md
# Serial Receive Status Flag Controller

This block keeps the receive data register of a serial port together with the two status flags that guard it. The flags are a data-full flag and an overrun flag. When the receive shifter finishes a byte, it sends a one-cycle completion pulse with the byte. The block then either loads the byte and marks the register full, or records an overrun and discards the byte. It also drives a receive interrupt request. When an overrun is pending, it asserts a halt that stops further reception and, in synchronous mode, stops transmission as well.

Software reads the two flags through a small status port. A flag can be cleared only by writing 0 to it after a status read has returned it as 1. A DMA read of the data register also clears the data-full flag. Writing 1 to a flag has no effect. The receive-enable bit gates new receptions, but dropping it does not disturb the held byte or either flag.

Top module: `rx_flag_ctrl`

## Requirements
- R1: After reset, both flags, the data register, the interrupt request and both halt outputs are 0.
- R2: A completion pulse with receive enabled, no overrun pending and data-full at 0 loads the byte into the data register and sets data-full. Both take effect on the next clock edge.
- R3: The status word has data-full at bit 0 and overrun at bit 1, and it always reflects the current flags. A write whose bit for a flag is 0 clears that flag if a status read returned that flag as 1 since the flag last set.
- R4: A write of 0 to a flag that has not been read as 1 since it last set leaves the flag unchanged.
- R5: A DMA read strobe clears data-full on the next edge and leaves the overrun flag unchanged.
- R6: A completion pulse that arrives while data-full is 1 (receive enabled, no overrun pending) sets overrun. The data register keeps its earlier byte.
- R7: While overrun is 1, completion pulses are ignored and the receive halt is 1. The transmit halt equals overrun AND the synchronous-mode input.
- R8: With receive enable at 0, completion pulses are ignored, and the data register and both flags keep their values.
- R9: Writing 1 to a flag bit never sets or changes that flag.
- R10: The interrupt request equals data-full AND the interrupt-enable input.
- R11: If a completion pulse and a clearing write for data-full fall in the same cycle while data-full is 1, the overrun sets and data-full stays 1.
- R12: Overrun clears only through the read-then-write-0 sequence. DMA reads do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_done_i | input | 1 | One-cycle receive-complete pulse from the shifter |
| rx_byte_i | input | DATA_W | Byte assembled by the shifter |
| rx_en_i | input | 1 | Receive enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| sync_mode_i | input | 1 | 1 = synchronous mode |
| stat_rd_i | input | 1 | Status read strobe |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 2 | Status write data (bit 0 data-full, bit 1 overrun) |
| stat_rdata_o | output | 2 | Status read data (bit 0 data-full, bit 1 overrun) |
| dma_rd_i | input | 1 | DMA read of the data register |
| rdata_o | output | DATA_W | Receive data register |
| full_o | output | 1 | Data-full flag |
| ovr_o | output | 1 | Overrun flag |
| rxi_o | output | 1 | Receive interrupt request |
| rx_halt_o | output | 1 | Reception halted by pending overrun |
| tx_halt_o | output | 1 | Transmission halted (synchronous mode, overrun pending) |

## Verification
Every flag and the data register change on the first clock edge after the cycle that carries the stimulus. The status word, interrupt request and halts follow the flags combinationally, so they become valid in that same cycle. The driver applies one stimulus per cycle at the falling edge and queues the expected state, tagged as due on the next rising edge. The monitor samples a quarter period after each rising edge, when the stimulus for the next cycle has not yet changed, and compares only items whose due edge has passed.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;
  // Flag indices; these are also bit positions in the status word.
  localparam int FLAG_FULL = 0;
  localparam int FLAG_OVR  = 1;
  localparam int NUM_FLAGS = 2;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rx_flag_cell.sv
module rx_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr0_i,
  input  logic force_clr_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr;

  always_comb begin
    clr    = (wr0_i & arm_q) | force_clr_i;
    flag_d = set_i | (flag_q & ~clr);
    arm_d  = flag_d & (arm_q | (rd_i & flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R9
  write_one_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_i) |=> !flag_q);
  // R4
  unread_clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q && !force_clr_i) |=> flag_q);
endmodule

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (load_i) data_d = byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;

  // R6
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(data_q));
endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
  import rx_flag_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_en_i,
  input  logic              rx_ie_i,
  input  logic              sync_mode_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [1:0]        stat_wdata_i,
  output logic [1:0]        stat_rdata_o,
  input  logic              dma_rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              rxi_o,
  output logic              rx_halt_o,
  output logic              tx_halt_o
);
  logic      rst_q_n;
  flag_vec_t flags;
  flag_vec_t set_vec;
  flag_vec_t frc_vec;
  flag_vec_t wr0_vec;
  logic      accept;
  logic      load;

  rx_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  always_comb begin
    accept                = rx_done_i & rx_en_i & ~flags[FLAG_OVR];
    load                  = accept & ~flags[FLAG_FULL];
    set_vec[FLAG_FULL]    = accept;
    set_vec[FLAG_OVR]     = accept & flags[FLAG_FULL];
    frc_vec[FLAG_FULL]    = dma_rd_i;
    frc_vec[FLAG_OVR]     = 1'b0;
    wr0_vec               = {NUM_FLAGS{stat_wr_i}} & ~stat_wdata_i;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    rx_flag_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_q_n),
      .set_i       (set_vec[i]),
      .wr0_i       (wr0_vec[i]),
      .force_clr_i (frc_vec[i]),
      .rd_i        (stat_rd_i),
      .flag_o      (flags[i])
    );
  end

  rx_data_hold #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (load),
    .byte_i (rx_byte_i),
    .data_o (rdata_o)
  );

  assign full_o       = flags[FLAG_FULL];
  assign ovr_o        = flags[FLAG_OVR];
  assign stat_rdata_o = flags;
  assign rxi_o        = flags[FLAG_FULL] & rx_ie_i;
  assign rx_halt_o    = flags[FLAG_OVR];
  assign tx_halt_o    = flags[FLAG_OVR] & sync_mode_i;

  // R6
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rx_done_i && rx_en_i && full_o && !ovr_o) |=> (ovr_o && $stable(rdata_o)));
  // R7
  halted_ignores_rx_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ovr_o && rx_done_i) |=> $stable(rdata_o));
  // R8
  disabled_ignores_rx_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!rx_en_i && !dma_rd_i && !stat_wr_i) |=> ($stable(rdata_o) && $stable(full_o) && $stable(ovr_o)));
  // R5
  dma_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dma_rd_i && !(rx_done_i && rx_en_i && !ovr_o)) |=> !full_o);
  // R12
  dma_keeps_ovr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ovr_o && !stat_wr_i) |=> ovr_o);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (full_o && !ovr_o && rx_done_i && rx_en_i && stat_wr_i && !stat_wdata_i[0]) |=> (full_o && ovr_o));
endmodule

// File: tb/rx_flag_ctrl_test.sv
`timescale 1ns/1ps
module rx_flag_ctrl_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_done, rx_en, rx_ie, sync_mode, stat_rd, stat_wr, dma_rd;
  logic [DW-1:0] rx_byte;
  logic [1:0]    stat_wdata, stat_rdata;
  logic [DW-1:0] rdata;
  logic          full, ovr, rxi, rx_halt, tx_halt;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int            due;
    string         tag;
    logic          f;
    logic          o;
    logic [DW-1:0] d;
    logic          irq;
    logic          rh;
    logic          th;
  } exp_t;
  exp_t q[$];

  rx_flag_ctrl #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done), .rx_byte_i(rx_byte),
    .rx_en_i(rx_en), .rx_ie_i(rx_ie), .sync_mode_i(sync_mode),
    .stat_rd_i(stat_rd), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata),
    .stat_rdata_o(stat_rdata), .dma_rd_i(dma_rd), .rdata_o(rdata),
    .full_o(full), .ovr_o(ovr), .rxi_o(rxi), .rx_halt_o(rx_halt), .tx_halt_o(tx_halt)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic compare(input exp_t e);
    tests++;
    if (full !== e.f || ovr !== e.o || rdata !== e.d || rxi !== e.irq ||
        rx_halt !== e.rh || tx_halt !== e.th || stat_rdata !== {e.o, e.f}) begin
      fails++;
      $display("FAIL %s: got full=%b ovr=%b data=%h rxi=%b rxh=%b txh=%b stat=%b, exp full=%b ovr=%b data=%h rxi=%b rxh=%b txh=%b stat=%b",
               e.tag, full, ovr, rdata, rxi, rx_halt, tx_halt, stat_rdata,
               e.f, e.o, e.d, e.irq, e.rh, e.th, {e.o, e.f});
    end
  endtask

  // Monitor: a quarter period after each rising edge.
  always begin
    @(posedge clk);
    #5;
    while (q.size() > 0 && q[0].due <= cyc) compare(q.pop_front());
  end

  // Driver: one stimulus cycle, expected state queued for the next edge.
  task automatic step(input string tag, input logic rxd, input logic [DW-1:0] b,
                      input logic en, input logic rd, input logic wr,
                      input logic [1:0] wd, input logic dma, input logic ie,
                      input logic sy, input logic ef, input logic eo,
                      input logic [DW-1:0] ed);
    exp_t e;
    @(negedge clk);
    rx_done = rxd; rx_byte = b; rx_en = en; stat_rd = rd; stat_wr = wr;
    stat_wdata = wd; dma_rd = dma; rx_ie = ie; sync_mode = sy;
    e.due = cyc + 1; e.tag = tag; e.f = ef; e.o = eo; e.d = ed;
    e.irq = ef & ie; e.rh = eo; e.th = eo & sy;
    q.push_back(e);
  endtask

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, got no completion, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; rx_done = 0; rx_byte = '0; rx_en = 0; rx_ie = 0; sync_mode = 0;
    stat_rd = 0; stat_wr = 0; stat_wdata = 2'b11; dma_rd = 0;
    repeat (3) @(posedge clk);
    #5;
    r.due = 0; r.tag = "R1 reset"; r.f = 0; r.o = 0; r.d = '0; r.irq = 0; r.rh = 0; r.th = 0;
    compare(r);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    //    tag                       rxd b      en rd wr wd     dma ie sy  f  o  data
    step("R2/R10 first byte",        1, 8'hA5, 1, 0, 0, 2'b11, 0, 1, 1, 1, 0, 8'hA5);
    step("R4 write0 unread",         0, 8'h00, 1, 0, 1, 2'b00, 0, 1, 1, 1, 0, 8'hA5);
    step("R3 status read",           0, 8'h00, 1, 1, 0, 2'b11, 0, 1, 1, 1, 0, 8'hA5);
    step("R3/R9 clear full",         0, 8'h00, 1, 0, 1, 2'b10, 0, 1, 1, 0, 0, 8'hA5);
    step("R2 second byte",           1, 8'h3C, 1, 0, 0, 2'b11, 0, 1, 1, 1, 0, 8'h3C);
    step("R6 overrun keeps data",    1, 8'h77, 1, 0, 0, 2'b11, 0, 1, 1, 1, 1, 8'h3C);
    step("R7 halted rx ignored",     1, 8'h11, 1, 0, 0, 2'b11, 0, 1, 1, 1, 1, 8'h3C);
    step("R7 async no tx halt",      0, 8'h00, 1, 1, 0, 2'b11, 0, 1, 0, 1, 1, 8'h3C);
    step("R9 write ones",            0, 8'h00, 1, 0, 1, 2'b11, 0, 1, 0, 1, 1, 8'h3C);
    step("R5/R12 dma read",          0, 8'h00, 1, 0, 0, 2'b11, 1, 1, 0, 0, 1, 8'h3C);
    step("R7 rx ignored full=0",     1, 8'h22, 1, 0, 0, 2'b11, 0, 1, 0, 0, 1, 8'h3C);
    step("R12 clear overrun",        0, 8'h00, 1, 0, 1, 2'b01, 0, 1, 0, 0, 0, 8'h3C);
    step("R8 rx disabled",           1, 8'h44, 0, 0, 0, 2'b11, 0, 1, 0, 0, 0, 8'h3C);
    step("R2 byte after disable",    1, 8'h55, 1, 0, 0, 2'b11, 0, 1, 0, 1, 0, 8'h55);
    step("R8 enable drop keeps",     0, 8'h00, 0, 0, 0, 2'b11, 0, 1, 0, 1, 0, 8'h55);
    step("R10 irq masked",           0, 8'h00, 1, 0, 0, 2'b11, 0, 0, 0, 1, 0, 8'h55);
    step("R3 read before race",      0, 8'h00, 1, 1, 0, 2'b11, 0, 1, 1, 1, 0, 8'h55);
    step("R11 set beats clear",      1, 8'h66, 1, 0, 1, 2'b10, 0, 1, 1, 1, 1, 8'h55);
    step("R7 sync tx halt",          0, 8'h00, 1, 0, 0, 2'b11, 0, 1, 1, 1, 1, 8'h55);
    step("R4 ovr write0 unread",     0, 8'h00, 1, 0, 1, 2'b01, 0, 1, 1, 1, 1, 8'h55);
    step("idle",                     0, 8'h00, 1, 0, 0, 2'b11, 0, 1, 1, 1, 1, 8'h55);
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule